// File: doc/BRIEF.md
# DMA Channel Request and Trigger Gate

This block lives inside one channel of a DMA controller. It picks the request that paces the channel and sends it to the read side or the write side of the transfer engine. It also decides whether the scheduler may launch the first burst of a block, based on an optional external trigger.

In software-request mode the channel copies memory to memory. The channel paces itself, so both port requests stay asserted and the peripheral request select is not used. In hardware mode, one of 128 peripheral request lines is selected. A direction flag steers that line to either the read port or the write port.

The trigger comes from one of 64 inputs. It can be masked, or armed on a rising edge or on a falling edge. Each detected edge sets a single pending flag, and the flag opens the burst gate. The scheduler reports two kinds of start: the start of a block, and the start of a repeated-block sequence. The start that matches the trigger granularity uses up the pending flag.

Top module: `chan_req_gate`

## Requirements
- R1: When `ch_en` is 1 and `sw_req` is 1, `rd_req` and `wr_req` are both 1 whatever `req_sel`, `dst_req` and `periph_req` hold.
- R2: When `ch_en` is 1 and `sw_req` is 0, the pacing request is `periph_req[req_sel]`, with bit index equal to the select value. The outputs follow it combinationally, in the same cycle.
- R3: In hardware mode, `dst_req`=0 drives the pacing request on `rd_req` and holds `wr_req` at 0. `dst_req`=1 drives it on `wr_req` and holds `rd_req` at 0.
- R4: The trigger polarity decodes as follows: 2'b01 arms on a rising edge of `trig_in[trig_sel]` and 2'b10 arms on a falling edge. An edge on the input raises `burst_ok` after exactly three rising clock edges. An edge of the other direction does nothing.
- R5: Polarity 2'b00 or 2'b11 means the trigger is masked. `burst_ok` is then 1 and `trig_mode` has no effect.
- R6: With an armed polarity, `burst_ok` is 0 until a hit is pending. When the conditioned start strobe is sampled while a hit is pending, `burst_ok` is 0 from the next cycle.
- R7: Trigger modes 2'b00, 2'b10 and 2'b11 are block-level. The conditioned start is `blk_start`.
- R8: Trigger mode 2'b01 is repeated-block level when the parameter TWO_D is 1. In that case the conditioned start is `rblk_start`, and `blk_start` alone leaves the pending hit in place. When TWO_D is 0, mode 2'b01 behaves as in R7.
- R9: The pending hit is one flag. A second hit that arrives while a hit is already pending is dropped, so a single conditioned start closes the gate again.
- R10: When `ch_en` is 0, both port requests are 0, the pending hit is cleared, and trigger hits are not recorded.
- R11: Only the input chosen by `trig_sel` can set a pending hit. Edges on any other trigger input have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable |
| sw_req | input | 1 | Software (memory-to-memory) request mode |
| req_sel | input | 7 | Peripheral request select |
| dst_req | input | 1 | 0: request paces the read port, 1: request paces the write port |
| trig_mode | input | 2 | Trigger granularity |
| trig_pol | input | 2 | Trigger edge polarity |
| trig_sel | input | 6 | Trigger input select |
| periph_req | input | 128 | Peripheral request lines |
| trig_in | input | 64 | Trigger input lines |
| blk_start | input | 1 | Strobe: first burst of a block starts |
| rblk_start | input | 1 | Strobe: first burst of a repeated-block sequence starts |
| rd_req | output | 1 | Read-port request |
| wr_req | output | 1 | Write-port request |
| burst_ok | output | 1 | First burst may start |

## Verification
The bench checks the exact three-edge trigger latency. A design with one synchronizer stage too many or too few opens the gate a cycle off, and the bench catches it on the cycle before and the cycle of the expected opening. The bench fires two hits before a single start. A design that counts hits would keep the gate open after that start.

Mode 01 runs on a two-dimensional channel and on a flat channel side by side. A design that ignores the TWO_D parameter would consume the hit on the wrong strobe in one of the two. Further directed cases cover:
- edges of the opposite polarity
- edges on trigger inputs that are not selected
- hits that arrive while the channel is disabled

A design that leaks any of these would open the gate when it should stay shut. Random configurations exercise the request routing, including software mode, where any stray use of the select would show up.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;

  typedef enum logic [1:0] {
    POL_MASKED   = 2'b00,
    POL_RISE     = 2'b01,
    POL_FALL     = 2'b10,
    POL_MASKED_B = 2'b11
  } trig_pol_e;

  typedef enum logic [1:0] {
    GRAN_BLOCK   = 2'b00,
    GRAN_REPEAT  = 2'b01,
    GRAN_RSVD_A  = 2'b10,
    GRAN_RSVD_B  = 2'b11
  } trig_gran_e;

  // Gating is active only for the two edge encodings.
  function automatic logic pol_armed(input logic [1:0] pol);
    return (pol == POL_RISE) || (pol == POL_FALL);
  endfunction

  // Edge detection on the synchronized trigger.
  function automatic logic edge_seen(input logic [1:0] pol,
                                     input logic cur,
                                     input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (pol)
      POL_RISE: return rise;
      POL_FALL: return fall;
      default:  return 1'b0;
    endcase
  endfunction

  // Repeated-block granularity exists only on two-dimensional channels.
  function automatic logic repeat_level(input logic [1:0] mode,
                                        input bit two_d);
    return two_d && (mode == GRAN_REPEAT);
  endfunction

  // Port request routing: returns {write, read}.
  function automatic logic [1:0] route_req(input logic en,
                                           input logic sw,
                                           input logic dst,
                                           input logic paced);
    logic [1:0] r;
    if (!en)      r = 2'b00;
    else if (sw)  r = 2'b11;
    else if (dst) r = {paced, 1'b0};
    else          r = {1'b0, paced};
    return r;
  endfunction

endpackage

// File: rtl/chan_req_route.sv
module chan_req_route
  import chan_gate_pkg::*;
#(
  parameter int NUM_REQ = 128,
  localparam int SEL_W  = $clog2(NUM_REQ)
) (
  input  logic               ch_en,
  input  logic               sw_req,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic               dst_req,
  input  logic [NUM_REQ-1:0] periph_req,
  output logic               paced,
  output logic               rd_req,
  output logic               wr_req
);

  logic [1:0] ports;

  // Out-of-range select values read as an idle request.
  always_comb begin
    paced = 1'b0;
    if (int'(req_sel) < NUM_REQ) paced = periph_req[req_sel];
  end

  always_comb begin
    ports  = route_req(ch_en, sw_req, dst_req, paced);
    rd_req = ports[0];
    wr_req = ports[1];
  end

endmodule

// File: rtl/chan_trig_sync.sv
module chan_trig_sync
  import chan_gate_pkg::*;
#(
  parameter int NUM_TRIG = 64,
  parameter int STAGES   = 2,
  localparam int TSEL_W  = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TSEL_W-1:0]   trig_sel,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic [1:0]          trig_pol,
  output logic                trig_hit
);

  logic              raw;
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // Select first, so only one synchronizer chain is needed.
  always_comb begin
    raw = 1'b0;
    if (int'(trig_sel) < NUM_TRIG) raw = trig_in[trig_sel];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign trig_hit = edge_seen(trig_pol, sync_q[STAGES-1], prev_q);

endmodule

// File: rtl/chan_trig_pend.sv
module chan_trig_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_en,
  input  logic gate_en,
  input  logic trig_hit,
  input  logic consume,
  output logic pending
);

  logic pend_d;

  // One flag: a hit counts only while nothing is pending.
  always_comb begin
    pend_d = 1'b0;
    if (ch_en && gate_en) begin
      if (pending) pend_d = ~consume;
      else         pend_d = trig_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pend_d;
  end

endmodule

// File: rtl/chan_req_gate.sv
module chan_req_gate
  import chan_gate_pkg::*;
#(
  parameter int NUM_REQ     = 128,
  parameter int NUM_TRIG    = 64,
  parameter bit TWO_D       = 1'b1,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_REQ),
  localparam int TSEL_W     = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch_en,
  input  logic                sw_req,
  input  logic [SEL_W-1:0]    req_sel,
  input  logic                dst_req,
  input  logic [1:0]          trig_mode,
  input  logic [1:0]          trig_pol,
  input  logic [TSEL_W-1:0]   trig_sel,
  input  logic [NUM_REQ-1:0]  periph_req,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                blk_start,
  input  logic                rblk_start,
  output logic                rd_req,
  output logic                wr_req,
  output logic                burst_ok
);

  // Named internal events, visible to the bound checker.
  logic paced;
  logic gate_en;
  logic rpt_gran;
  logic trig_hit;
  logic consume;
  logic trig_pend;

  chan_req_route #(.NUM_REQ(NUM_REQ)) u_route (
    .ch_en      (ch_en),
    .sw_req     (sw_req),
    .req_sel    (req_sel),
    .dst_req    (dst_req),
    .periph_req (periph_req),
    .paced      (paced),
    .rd_req     (rd_req),
    .wr_req     (wr_req)
  );

  chan_trig_sync #(.NUM_TRIG(NUM_TRIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_sel (trig_sel),
    .trig_in  (trig_in),
    .trig_pol (trig_pol),
    .trig_hit (trig_hit)
  );

  always_comb begin
    gate_en  = pol_armed(trig_pol);
    rpt_gran = repeat_level(trig_mode, TWO_D);
    consume  = gate_en & (rpt_gran ? rblk_start : blk_start);
  end

  chan_trig_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_en    (ch_en),
    .gate_en  (gate_en),
    .trig_hit (trig_hit),
    .consume  (consume),
    .pending  (trig_pend)
  );

  assign burst_ok = ~gate_en | trig_pend;

endmodule

// File: rtl/chan_req_gate_chk.sv
module chan_req_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_en,
  input logic       sw_req,
  input logic       dst_req,
  input logic [1:0] trig_pol,
  input logic       rd_req,
  input logic       wr_req,
  input logic       burst_ok,
  input logic       trig_pend,
  input logic       consume
);

  logic armed;
  assign armed = (trig_pol == 2'b01) || (trig_pol == 2'b10);

  a_r1_sw_both: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en && sw_req |-> rd_req && wr_req);

  a_r3_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en && !sw_req && !dst_req |-> !wr_req);

  a_r3_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en && !sw_req && dst_req |-> !rd_req);

  a_r5_masked_open: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> burst_ok);

  a_r6_closed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !trig_pend |-> !burst_ok);

  a_r6_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en && consume && trig_pend |=> !trig_pend);

  a_r9_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en && armed && trig_pend && !consume |=> trig_pend);

  a_r10_idle_ports: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |-> !rd_req && !wr_req);

  a_r10_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !trig_pend);

endmodule

bind chan_req_gate chan_req_gate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_en     (ch_en),
  .sw_req    (sw_req),
  .dst_req   (dst_req),
  .trig_pol  (trig_pol),
  .rd_req    (rd_req),
  .wr_req    (wr_req),
  .burst_ok  (burst_ok),
  .trig_pend (trig_pend),
  .consume   (consume)
);

// File: tb/tb_chan_req_gate.sv
module tb_chan_req_gate;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ch_en = 1'b0;
  logic         sw_req = 1'b0;
  logic [6:0]   req_sel = '0;
  logic         dst_req = 1'b0;
  logic [1:0]   trig_mode = 2'b00;
  logic [1:0]   trig_pol = 2'b00;
  logic [5:0]   trig_sel = '0;
  logic [127:0] periph_req = '0;
  logic [63:0]  trig_in = '0;
  logic         blk_start = 1'b0;
  logic         rblk_start = 1'b0;
  logic         rd_req, wr_req, burst_ok;
  logic         rd_f, wr_f, ok_f;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chan_req_gate #(.TWO_D(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .sw_req(sw_req),
    .req_sel(req_sel), .dst_req(dst_req), .trig_mode(trig_mode),
    .trig_pol(trig_pol), .trig_sel(trig_sel), .periph_req(periph_req),
    .trig_in(trig_in), .blk_start(blk_start), .rblk_start(rblk_start),
    .rd_req(rd_req), .wr_req(wr_req), .burst_ok(burst_ok));

  chan_req_gate #(.TWO_D(1'b0)) dut_flat (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .sw_req(sw_req),
    .req_sel(req_sel), .dst_req(dst_req), .trig_mode(trig_mode),
    .trig_pol(trig_pol), .trig_sel(trig_sel), .periph_req(periph_req),
    .trig_in(trig_in), .blk_start(blk_start), .rblk_start(rblk_start),
    .rd_req(rd_f), .wr_req(wr_f), .burst_ok(ok_f));

  // Expected {wr, rd}, derived from R1, R2, R3 and R10.
  function automatic logic [1:0] want_ports(logic en, logic sw, logic dst,
                                            logic [127:0] vec, logic [6:0] sel);
    logic hit;
    hit = |(vec & (128'b1 << sel));
    if (!en) return 2'b00;
    if (sw)  return 2'b11;
    return dst ? {hit, 1'b0} : {1'b0, hit};
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic start_pulse(input logic b, input logic r);
    blk_start = b;
    rblk_start = r;
    step(1);
    blk_start = 1'b0;
    rblk_start = 1'b0;
  endtask

  task automatic set_trig(input int idx, input logic v);
    trig_in[idx] = v;
    step(3);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    step(3);
    rst_n = 1'b1;
    step(1);
    // Reset state.
    chk(rd_req, 1'b0, "R10 reset rd");
    chk(wr_req, 1'b0, "R10 reset wr");
    chk(burst_ok, 1'b1, "R5 reset gate");

    // Random request routing.
    for (int i = 0; i < 300; i++) begin
      logic [1:0] w;
      ch_en   = ($urandom % 4) != 0;
      sw_req  = ($urandom % 3) == 0;
      dst_req = $urandom % 2;
      req_sel = $urandom % 128;
      periph_req = {$urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 0) periph_req[req_sel] = ~periph_req[req_sel];
      #1;
      w = want_ports(ch_en, sw_req, dst_req, periph_req, req_sel);
      chk(rd_req, w[0], "R1 R2 R3 R10 routing rd");
      chk(wr_req, w[1], "R1 R2 R3 R10 routing wr");
      step(1);
    end
    ch_en = 1'b1;
    sw_req = 1'b0;
    periph_req = '0;

    // Rising edge, exact latency.
    trig_sel = 6'd5;
    trig_pol = 2'b01;
    step(1);
    chk(burst_ok, 1'b0, "R6 armed no hit");
    trig_in[5] = 1'b1;
    step(2);
    chk(burst_ok, 1'b0, "R4 two edges early");
    step(1);
    chk(burst_ok, 1'b1, "R4 rise opens on third edge");
    chk(ok_f, 1'b1, "R4 rise opens flat");
    start_pulse(1'b1, 1'b0);
    chk(burst_ok, 1'b0, "R7 block start consumes");
    chk(ok_f, 1'b0, "R7 block start consumes flat");

    // Two hits then one start: the second hit is dropped.
    set_trig(5, 1'b0);
    chk(burst_ok, 1'b0, "R4 falling ignored under rise");
    set_trig(5, 1'b1);
    chk(burst_ok, 1'b1, "R4 second rise opens");
    set_trig(5, 1'b0);
    set_trig(5, 1'b1);
    start_pulse(1'b1, 1'b0);
    chk(burst_ok, 1'b0, "R9 extra hit not counted");

    // Falling polarity.
    trig_pol = 2'b10;
    step(1);
    chk(burst_ok, 1'b0, "R6 fall armed");
    set_trig(5, 1'b0);
    chk(burst_ok, 1'b1, "R4 fall opens");
    start_pulse(1'b1, 1'b0);
    set_trig(5, 1'b1);
    chk(burst_ok, 1'b0, "R4 rise ignored under fall");

    // Masked encodings.
    trig_pol = 2'b11;
    trig_mode = 2'b01;
    step(1);
    chk(burst_ok, 1'b1, "R5 pol 11 open");
    trig_pol = 2'b00;
    start_pulse(1'b1, 1'b1);
    chk(burst_ok, 1'b1, "R5 pol 00 open after starts");

    // Repeated-block granularity.
    trig_pol = 2'b01;
    set_trig(5, 1'b0);
    set_trig(5, 1'b1);
    chk(burst_ok, 1'b1, "R8 hit pending");
    start_pulse(1'b1, 1'b0);
    chk(burst_ok, 1'b1, "R8 block start keeps hit on 2D");
    chk(ok_f, 1'b0, "R8 flat channel acts as block mode");
    start_pulse(1'b1, 1'b1);
    chk(burst_ok, 1'b0, "R8 repeat start consumes");

    // Mode 10 behaves at block level.
    trig_mode = 2'b10;
    set_trig(5, 1'b0);
    set_trig(5, 1'b1);
    start_pulse(1'b1, 1'b0);
    chk(burst_ok, 1'b0, "R7 mode 10 block level");

    // Trigger select.
    trig_mode = 2'b00;
    set_trig(9, 1'b1);
    chk(burst_ok, 1'b0, "R11 unselected input ignored");
    trig_sel = 6'd40;
    step(1);
    set_trig(40, 1'b1);
    chk(burst_ok, 1'b1, "R11 selected input 40 opens");
    start_pulse(1'b1, 1'b0);

    // Channel disable.
    set_trig(40, 1'b0);
    set_trig(40, 1'b1);
    chk(burst_ok, 1'b1, "R10 hit pending before disable");
    ch_en = 1'b0;
    periph_req = '1;
    step(1);
    chk(rd_req, 1'b0, "R10 disabled rd");
    chk(wr_req, 1'b0, "R10 disabled wr");
    ch_en = 1'b1;
    periph_req = '0;
    step(1);
    chk(burst_ok, 1'b0, "R10 pending cleared");
    ch_en = 1'b0;
    set_trig(40, 1'b0);
    set_trig(40, 1'b1);
    ch_en = 1'b1;
    step(1);
    chk(burst_ok, 1'b0, "R10 hit while disabled ignored");

    finish_up();
  end

endmodule